// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block generates the interrupt request of a UART whose transmit and receive queues can run either as 32-entry FIFOs or as single holding registers. It watches the occupancy counts of both queues and the clear-to-send input. It keeps one pending bit per interrupt source and gates those bits with a per-source enable mask. All gated sources are merged onto one interrupt line. A small register port lets software read the pending and gated status, program the mask and acknowledge sources by writing ones.

In queue mode, the receive source fires when the receive occupancy reaches a selectable fraction of the depth. The transmit source fires when the transmit occupancy falls to or below a selectable fraction. With the queues bypassed, the receive source fires whenever the holding register holds data, and the transmit source fires whenever it is empty. Any change of the clear-to-send input, in either direction, latches a third source.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the pending status, the mask and the interrupt output are all zero.
- R2: With `fifo_en` high, pending bit 0 (receive) is set on the clock edge after `rx_count` is at or above the level picked by `rx_lvl_sel`. Codes 0, 1, 2, 3 and 4 give 1/8, 1/4, 1/2, 3/4 and 7/8 of the depth, which is 4, 8, 16, 24 and 28 entries at depth 32. Codes 5 to 7 act as 1/2. A count of 1 does not set the bit at any code.
- R3: With `fifo_en` high, pending bit 1 (transmit) is set on the clock edge after `tx_count` is at or below the level picked by `tx_lvl_sel`, using the same code mapping as R2.
- R4: With `fifo_en` low, bit 0 is set after any clock with a nonzero `rx_count`, and bit 1 is set after any clock with `tx_count` equal to zero. The level selects have no effect in this mode.
- R5: Pending bit 2 is set on the edge after `cts_in` changes value, on a rise or a fall. It stays set until it is cleared.
- R6: A write to address 3 clears each pending bit whose data bit is 1. If the source's condition holds in that same cycle, the bit stays set.
- R7: Reading address 0 returns the pending status. Reading address 1 returns pending AND mask. Writing address 2 loads the mask, and reading address 2 returns it. Bit 0 is receive, bit 1 is transmit and bit 2 is clear-to-send, at every address.
- R8: `irq_o` is high exactly when the gated status is nonzero. It follows the flopped status with no combinational path from the data inputs.
- R9: Address 3 reads as zero. Writes to addresses 0 and 1 change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| rx_count | input | 6 | Receive occupancy |
| tx_count | input | 6 | Transmit occupancy |
| rx_lvl_sel | input | 3 | Receive threshold code |
| tx_lvl_sel | input | 3 | Transmit threshold code |
| cts_in | input | 1 | Clear-to-send, already synchronous |
| reg_sel | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 3 | Write data |
| rd_data | output | 3 | Read data for `reg_sel` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The threshold logic is driven with occupancies just below, exactly at and above each selectable level, in both directions. This shows an off-by-one comparison and a wrong code mapping, including the fallback codes and the single-entry receive case. The same counts are then applied with the queues bypassed, which shows whether the mode switch picks the empty/full conditions and ignores the level codes. Rising and falling clear-to-send edges, long quiet spans and clears issued while a condition persists or an edge arrives show the difference between latched edge sources and re-arming level sources. Mask patterns that hide one source while another stays visible show the gating and the merge onto the request line.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC    = 3;
    localparam int SRC_RX  = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_CTS = 2;

    typedef enum logic [1:0] {
        ADDR_RAW  = 2'd0,
        ADDR_GATE = 2'd1,
        ADDR_MASK = 2'd2,
        ADDR_ACK  = 2'd3
    } reg_addr_e;

    typedef logic [NSRC-1:0] src_vec_t;

    // fraction of the queue depth chosen by a 3-bit code
    function automatic int unsigned trig_level(logic [2:0] code, int unsigned depth);
        case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd3:    return (3 * depth) / 4;
            3'd4:    return (7 * depth) / 8;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/uirq_cond.sv
module uirq_cond #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [2:0]       rx_lvl_sel,
    input  logic [2:0]       tx_lvl_sel,
    output logic             rx_hit,
    output logic             tx_hit
);
    import uirq_pkg::*;

    logic [CNT_W-1:0] rx_lvl;
    logic [CNT_W-1:0] tx_lvl;

    always_comb begin
        rx_lvl = CNT_W'(trig_level(rx_lvl_sel, DEPTH));
        tx_lvl = CNT_W'(trig_level(tx_lvl_sel, DEPTH));
        if (fifo_en) begin
            rx_hit = (rx_count >= rx_lvl);
            tx_hit = (tx_count <= tx_lvl);
        end else begin
            rx_hit = (rx_count != '0);
            tx_hit = (tx_count == '0);
        end
    end

endmodule

// File: rtl/uirq_edge.sv
module uirq_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic toggled
);
    logic sig_q;

    always_ff @(posedge clk) begin
        // reset loads the current level so no edge is seen on release
        sig_q <= sig_in;
    end

    assign toggled = !rst && (sig_q != sig_in);

endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] ack_vec,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_din,
    output logic [NSRC-1:0] raw_q,
    output logic [NSRC-1:0] mask_q,
    output logic            irq_q
);
    logic [NSRC-1:0] raw_d;
    logic [NSRC-1:0] mask_d;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // a new condition wins over an acknowledge in the same cycle
        assign raw_d[i] = set_vec[i] | (raw_q[i] & ~ack_vec[i]);

        always_ff @(posedge clk) begin
            if (rst) raw_q[i] <= 1'b0;
            else     raw_q[i] <= raw_d[i];
        end
    end

    assign mask_d = mask_we ? mask_din : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            irq_q  <= |(raw_d & mask_d);
        end
    end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fifo_en,
    input  logic [CNT_W-1:0]          rx_count,
    input  logic [CNT_W-1:0]          tx_count,
    input  logic [2:0]                rx_lvl_sel,
    input  logic [2:0]                tx_lvl_sel,
    input  logic                      cts_in,
    input  logic [1:0]                reg_sel,
    input  logic                      wr_en,
    input  logic [uirq_pkg::NSRC-1:0] wr_data,
    output logic [uirq_pkg::NSRC-1:0] rd_data,
    output logic                      irq_o
);
    import uirq_pkg::*;

    logic      rx_hit, tx_hit, cts_tog;
    src_vec_t  set_vec, ack_vec, raw_q, mask_q;
    logic      mask_we;
    reg_addr_e addr;

    uirq_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cond (
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_lvl_sel (rx_lvl_sel),
        .tx_lvl_sel (tx_lvl_sel),
        .rx_hit     (rx_hit),
        .tx_hit     (tx_hit)
    );

    uirq_edge u_cts (
        .clk     (clk),
        .rst     (rst),
        .sig_in  (cts_in),
        .toggled (cts_tog)
    );

    always_comb begin
        addr             = reg_addr_e'(reg_sel);
        set_vec          = '0;
        set_vec[SRC_RX]  = rx_hit;
        set_vec[SRC_TX]  = tx_hit;
        set_vec[SRC_CTS] = cts_tog;
        ack_vec          = (wr_en && addr == ADDR_ACK) ? wr_data : '0;
        mask_we          = wr_en && (addr == ADDR_MASK);
    end

    uirq_status #(.NSRC(NSRC)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .ack_vec  (ack_vec),
        .mask_we  (mask_we),
        .mask_din (wr_data),
        .raw_q    (raw_q),
        .mask_q   (mask_q),
        .irq_q    (irq_o)
    );

    always_comb begin
        case (addr)
            ADDR_RAW:  rd_data = raw_q;
            ADDR_GATE: rd_data = raw_q & mask_q;
            ADDR_MASK: rd_data = mask_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
    parameter int CNT_W = 6,
    parameter int NSRC  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             cts_in,
    input logic [1:0]       reg_sel,
    input logic             wr_en,
    input logic [NSRC-1:0]  wr_data,
    input logic [NSRC-1:0]  rd_data,
    input logic             irq_o,
    input logic [NSRC-1:0]  raw,
    input logic [NSRC-1:0]  mask
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw == '0 && mask == '0 && !irq_o));

    // R4
    direct_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && rx_count != '0) |=> raw[0]);

    // R4
    direct_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && tx_count == '0) |=> raw[1]);

    // R5
    cts_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (cts_in != $past(cts_in)) |=> raw[2]);

    // R6
    cts_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == 2'd3 && wr_data[2] && cts_in == $past(cts_in)) |=> !raw[2]);

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == 2'd2) |=> (mask == $past(wr_data)));

    // R8
    irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd1 && rd_data != '0) |-> irq_o);

    // R8
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd1 && rd_data == '0) |-> !irq_o);

    // R9
    ack_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd3) |-> (rd_data == '0));

endmodule

bind uart_irq_unit uirq_chk #(.CNT_W(CNT_W), .NSRC(uirq_pkg::NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .cts_in   (cts_in),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_o    (irq_o),
    .raw      (raw_q),
    .mask     (mask_q)
);

// File: tb/tb_uart_irq_unit.sv
module tb_uart_irq_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1;
    logic [5:0] rx_count = '0;
    logic [5:0] tx_count = 6'd32;
    logic [2:0] rx_lvl_sel = '0;
    logic [2:0] tx_lvl_sel = '0;
    logic       cts_in = 1'b0;
    logic [1:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic [2:0] rd_data;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_irq_unit dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_count(rx_count),
        .tx_count(tx_count), .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
        .cts_in(cts_in), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    typedef struct packed {
        logic       fe;
        logic [2:0] rs;
        logic [2:0] ts;
        logic [5:0] rc;
        logic [5:0] tc;
        logic [1:0] exp;
    } vec_t;

    // exp bit 0 = receive, bit 1 = transmit
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 3'd0, 6'd3,  6'd32, 2'b00},
        '{1'b1, 3'd0, 3'd0, 6'd4,  6'd32, 2'b01},
        '{1'b1, 3'd0, 3'd0, 6'd1,  6'd32, 2'b00},
        '{1'b1, 3'd1, 3'd0, 6'd7,  6'd32, 2'b00},
        '{1'b1, 3'd1, 3'd0, 6'd8,  6'd32, 2'b01},
        '{1'b1, 3'd2, 3'd0, 6'd16, 6'd32, 2'b01},
        '{1'b1, 3'd3, 3'd0, 6'd23, 6'd32, 2'b00},
        '{1'b1, 3'd4, 3'd0, 6'd28, 6'd32, 2'b01},
        '{1'b1, 3'd5, 3'd0, 6'd15, 6'd32, 2'b00},
        '{1'b1, 3'd0, 3'd0, 6'd0,  6'd4,  2'b10},
        '{1'b1, 3'd0, 3'd0, 6'd0,  6'd5,  2'b00},
        '{1'b1, 3'd0, 3'd2, 6'd0,  6'd16, 2'b10},
        '{1'b1, 3'd0, 3'd4, 6'd0,  6'd29, 2'b00},
        '{1'b1, 3'd0, 3'd4, 6'd0,  6'd28, 2'b10},
        '{1'b0, 3'd0, 3'd0, 6'd1,  6'd0,  2'b11},
        '{1'b0, 3'd0, 3'd0, 6'd0,  6'd1,  2'b00},
        '{1'b0, 3'd4, 3'd4, 6'd1,  6'd1,  2'b01}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [2:0] d);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [2:0] v);
        reg_sel = a;
        #1;
        v = rd_data;
    endtask

    task automatic neutral();
        fifo_en = 1'b1; rx_count = '0; tx_count = 6'd32;
        rx_lvl_sel = '0; tx_lvl_sel = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [2:0] v;
        string tag;
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check(v == 3'b000, "R1 raw", v, 0);
        rd(2'd1, v); check(v == 3'b000, "R1 gated", v, 0);
        rd(2'd2, v); check(v == 3'b000, "R1 mask", v, 0);
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);

        // threshold and mode table
        for (int i = 0; i < NV; i++) begin
            neutral();
            wr(2'd3, 3'b111);
            fifo_en = VECS[i].fe; rx_lvl_sel = VECS[i].rs; tx_lvl_sel = VECS[i].ts;
            rx_count = VECS[i].rc; tx_count = VECS[i].tc;
            step();
            rd(2'd0, v);
            if (!VECS[i].fe) tag = "R4 direct mode";
            else if (VECS[i].tc != 6'd32) tag = "R3 tx level";
            else tag = "R2 rx level";
            check(v[1:0] == VECS[i].exp, tag, v[1:0], VECS[i].exp);
        end

        // R7 mask load and readback
        neutral();
        wr(2'd3, 3'b111);
        wr(2'd2, 3'b101);
        rd(2'd2, v); check(v == 3'b101, "R7 mask readback", v, 5);

        // R8 receive visible through mask
        rx_count = 6'd4;
        step();
        rd(2'd1, v); check(v == 3'b001, "R7 gated rx", v, 1);
        check(irq_o == 1'b1, "R8 irq on gated rx", irq_o, 1);

        // R6 ack while condition holds leaves bit set
        wr(2'd3, 3'b001);
        rd(2'd0, v); check(v[0] == 1'b1, "R6 rx re-arms", v, 1);

        // R6 ack after condition gone clears it
        rx_count = 6'd0;
        wr(2'd3, 3'b001);
        rd(2'd0, v); check(v == 3'b000, "R6 rx cleared", v, 0);
        check(irq_o == 1'b0, "R8 irq drops", irq_o, 0);

        // R8 masked-out transmit source
        tx_count = 6'd0;
        step();
        rd(2'd0, v); check(v == 3'b010, "R3 tx pending", v, 2);
        rd(2'd1, v); check(v == 3'b000, "R7 tx hidden", v, 0);
        check(irq_o == 1'b0, "R8 irq with tx masked", irq_o, 0);
        tx_count = 6'd32;
        wr(2'd3, 3'b010);

        // R5 rising edge latches and holds
        cts_in = 1'b1;
        step();
        repeat (5) step();
        rd(2'd0, v); check(v == 3'b100, "R5 cts rise held", v, 4);
        check(irq_o == 1'b1, "R8 irq on cts", irq_o, 1);
        wr(2'd3, 3'b100);
        rd(2'd0, v); check(v == 3'b000, "R6 cts cleared", v, 0);

        // R5 falling edge
        cts_in = 1'b0;
        step();
        rd(2'd0, v); check(v == 3'b100, "R5 cts fall", v, 4);

        // R9 read-only addresses ignore writes, ack reads zero
        wr(2'd0, 3'b111);
        rd(2'd0, v); check(v == 3'b100, "R9 raw write ignored", v, 4);
        wr(2'd1, 3'b111);
        rd(2'd2, v); check(v == 3'b101, "R9 gated write ignored", v, 5);
        rd(2'd3, v); check(v == 3'b000, "R9 ack reads zero", v, 0);

        // R6 new edge in the ack cycle wins
        reg_sel = 2'd3; wr_data = 3'b100; wr_en = 1'b1; cts_in = 1'b1;
        step();
        wr_en = 1'b0;
        rd(2'd0, v); check(v == 3'b100, "R6 edge beats ack", v, 4);

        finish_run();
    end

endmodule